// File: doc/BRIEF.md
# PHY Management Bus Master

This block runs single read or write transactions on a two-wire PHY management bus: a clock line (`mdc`) and one shared data line, split here into an output value, an output enable and an input value for the pad. The host gives the PHY address, the register number, a read/write flag and 16 bits of write data, then pulses `cmd_start`. The block sends the 64-bit management frame with the most significant bit first. On a read it releases the data line and shifts in the 16 bits the PHY returns. It shows `busy` while the frame is on the wire. After that it raises a sticky `done` flag, which software polls.

The management clock comes from the system clock. A 3-bit divisor code chooses one of eight ratios, and the steps between them are not uniform. The code sits in a small configuration register that the host can write at any time. A transaction copies the code when it starts, so a new code changes the clock rate only from the next transaction on. Start requests that arrive while a transaction is running are dropped.

Top module: `mdio_master`

## Requirements
- R1: A write frame goes out at one bit per `mdc` period, first bit first. Its 64 bits are: 32 ones, start bits 0 then 1, opcode 0 then 1, PHY address MSB first, register number MSB first, turnaround 1 then 0, and the 16 write-data bits MSB first. `mdio_oe` is 1 for every bit.
- R2: A read frame uses the same header with opcode 1 then 0. `mdio_oe` is 1 for bits 0 to 45 and 0 from the turnaround (bit 46) to the end. The data line is sampled at each rising `mdc` edge of bits 48 to 63. `rd_data` holds those samples, the first one as bit 15.
- R3: The MDC period in system clocks is set by the divisor code: 0→8, 1→16, 2→32, 3→48, 4→64, 5→96, 6→128, 7→224. High time and low time are each half the period.
- R4: After reset the configuration code is 2 (divide by 32) until `cfg_wr` writes it.
- R5: A `cfg_wr` always updates the configuration code, even during a transaction. A transaction uses the code that was in place when it was accepted, so a write during a transaction affects only later transactions.
- R6: While busy, `mdio_o` changes only at falling edges of `mdc`, never while `mdc` is high or at a rising edge.
- R7: While not busy, `mdc` is 0 and `mdio_oe` is 0.
- R8: `busy` rises at the clock edge that accepts `cmd_start` and stays high for exactly 64 MDC periods. `done` rises at the edge where `busy` falls. `done` stays 1 until the next accepted start, and it clears at that start's edge.
- R9: A `cmd_start` given while busy is ignored. The running frame is not changed, and no second transaction follows.
- R10: Reset leaves `busy`, `done`, `mdc`, `mdio_oe` and `rd_data` all at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the divisor code register |
| cfg_div_code | input | 3 | Divisor code to store |
| cmd_start | input | 1 | Start a transaction (ignored while busy) |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register number 0..31 |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Sticky completion flag |
| rd_data | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management clock, idles low |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
With divisor half-period H, `busy` shows at the first falling system-clock edge after the start edge. It then stays high for exactly 128·H samples, and `done` becomes visible in the same sample in which `busy` drops. The bench takes every sample on the falling system-clock edge. It counts the clock cycles between the first two rising `mdc` edges and between the first rising and first falling edge, and compares these counts with the table value for the code in force at the start. Each data bit is captured one falling system-clock edge after the `mdc` rising edge. Read data from the modelled PHY changes only after that capture, so the sample the block takes at a rising edge always sees a settled value.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int HALF_W = 7;
    localparam logic [2:0] DIV_CODE_RST = 3'b010;

    // half of the MDC period, in system clocks, for each divisor code
    function automatic logic [HALF_W-1:0] div_half(input logic [2:0] code);
        logic [HALF_W-1:0] h;
        case (code)
            3'd0:    h = 7'd4;
            3'd1:    h = 7'd8;
            3'd2:    h = 7'd16;
            3'd3:    h = 7'd24;
            3'd4:    h = 7'd32;
            3'd5:    h = 7'd48;
            3'd6:    h = 7'd64;
            default: h = 7'd112;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              mdc,
    output logic              rise_now,
    output logic              fall_now
);

    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              mdc;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       toggle;

    always_comb begin
        st_d     = st_q;
        toggle   = run && (st_q.cnt == half - 1'b1);
        rise_now = toggle && !st_q.mdc;
        fall_now = toggle && st_q.mdc;
        if (!run) begin
            st_d = '0;
        end else if (toggle) begin
            st_d.cnt = '0;
            st_d.mdc = !st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc = st_q.mdc;

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng #(
    parameter int FRAME_W    = 64,
    parameter int TA_START   = 46,
    parameter int DATA_START = 48,
    parameter int DATA_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_frame,
    input  logic               load_rd,
    input  logic               rise_now,
    input  logic               fall_now,
    input  logic               mdio_i,
    output logic               active,
    output logic               done,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic [DATA_W-1:0]  rd_data
);

    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_W - 1);
    localparam logic [BIT_W-1:0] TA_IDX   = BIT_W'(TA_START);
    localparam logic [BIT_W-1:0] DAT_IDX  = BIT_W'(DATA_START);

    typedef struct packed {
        logic [FRAME_W-1:0] shift;
        logic [BIT_W-1:0]   bitn;
        logic               rd;
        logic               active;
        logic               done;
        logic [DATA_W-1:0]  rdata;
    } eng_state_t;

    eng_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.shift  = load_frame;
            st_d.bitn   = '0;
            st_d.rd     = load_rd;
            st_d.active = 1'b1;
            st_d.done   = 1'b0;
        end else if (st_q.active) begin
            if (rise_now && st_q.rd && (st_q.bitn >= DAT_IDX)) begin
                st_d.rdata = {st_q.rdata[DATA_W-2:0], mdio_i};
            end
            if (fall_now) begin
                if (st_q.bitn == LAST_IDX) begin
                    st_d.active = 1'b0;
                    st_d.done   = 1'b1;
                end else begin
                    st_d.shift = {st_q.shift[FRAME_W-2:0], 1'b0};
                    st_d.bitn  = st_q.bitn + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active  = st_q.active;
    assign done    = st_q.done;
    assign mdio_o  = st_q.active ? st_q.shift[FRAME_W-1] : 1'b1;
    assign mdio_oe = st_q.active && !(st_q.rd && (st_q.bitn >= TA_IDX));
    assign rd_data = st_q.rdata;

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int PHY_AW  = 5,
    parameter int REG_AW  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_div_code,
    input  logic              cmd_start,
    input  logic              cmd_read,
    input  logic [PHY_AW-1:0] cmd_phy,
    input  logic [REG_AW-1:0] cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    import mdio_pkg::*;

    localparam int TA_START   = PRE_LEN + 4 + PHY_AW + REG_AW;
    localparam int DATA_START = TA_START + 2;
    localparam int FRAME_W    = DATA_START + DATA_W;

    typedef struct packed {
        logic [2:0] cfg_code;
        logic [2:0] act_code;
    } top_state_t;

    top_state_t         st_d, st_q;
    logic               accept;
    logic [FRAME_W-1:0] frame;
    logic [HALF_W-1:0]  half;
    logic               rise_now, fall_now;
    logic               eng_active;

    always_comb begin
        st_d   = st_q;
        accept = cmd_start && !eng_active;
        if (cfg_wr) st_d.cfg_code = cfg_div_code;
        if (accept) st_d.act_code = st_q.cfg_code;
        frame = {{PRE_LEN{1'b1}}, 2'b01,
                 cmd_read ? 2'b10 : 2'b01,
                 cmd_phy, cmd_reg,
                 cmd_read ? 2'b00 : 2'b10,
                 cmd_read ? {DATA_W{1'b0}} : cmd_wdata};
        half = div_half(st_q.act_code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cfg_code: DIV_CODE_RST, act_code: DIV_CODE_RST};
        else        st_q <= st_d;
    end

    mdio_clk_div #(.HALF_W(HALF_W)) i_clk_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (eng_active),
        .half     (half),
        .mdc      (mdc),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    mdio_frame_eng #(
        .FRAME_W    (FRAME_W),
        .TA_START   (TA_START),
        .DATA_START (DATA_START),
        .DATA_W     (DATA_W)
    ) i_frame_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_frame (frame),
        .load_rd    (cmd_read),
        .rise_now   (rise_now),
        .fall_now   (fall_now),
        .mdio_i     (mdio_i),
        .active     (eng_active),
        .done       (done),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .rd_data    (rd_data)
    );

    assign busy = eng_active;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_on_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_clear_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> busy);

    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

    p_mdc_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy);

endmodule

bind mdio_master mdio_master_chk i_mdio_master_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_div_code = 3'd0;
    logic        cmd_start = 1'b0;
    logic        cmd_read = 1'b0;
    logic [4:0]  cmd_phy = '0;
    logic [4:0]  cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    mdio_master i_mdio_master (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_div_code(cfg_div_code),
        .cmd_start(cmd_start), .cmd_read(cmd_read), .cmd_phy(cmd_phy),
        .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    // ---------------- bus monitor and PHY model (falling clk edge) ----------
    int       cyc = 0;
    int       rise_cnt = 0;
    int       busy_cnt = 0;
    int       rise_cyc0 = 0, rise_cyc1 = 0, fall_cyc0 = 0;
    int       fall_seen = 0;
    logic     mdc_prev = 1'b0, busy_prev = 1'b0;
    logic     cap_o  [0:63];
    logic     cap_oe [0:63];
    logic [15:0] phy_val = '0;

    assign mdio_i = (rise_cnt >= 48 && rise_cnt < 64) ? phy_val[63 - rise_cnt] : 1'b1;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        mdc_prev  <= mdc;
        busy_prev <= busy;
        if (busy && !busy_prev) begin
            rise_cnt  <= 0;
            busy_cnt  <= 1;
            fall_seen <= 0;
        end else begin
            if (busy) busy_cnt <= busy_cnt + 1;
            if (mdc && !mdc_prev) begin
                if (rise_cnt < 64) begin
                    cap_o[rise_cnt]  <= mdio_o;
                    cap_oe[rise_cnt] <= mdio_oe;
                end
                if (rise_cnt == 0) rise_cyc0 <= cyc;
                if (rise_cnt == 1) rise_cyc1 <= cyc;
                rise_cnt <= rise_cnt + 1;
            end
            if (!mdc && mdc_prev && fall_seen == 0) begin
                fall_cyc0 <= cyc;
                fall_seen <= 1;
            end
        end
    end

    // ---------------- reference model ---------------------------------------
    function automatic int ref_period(input logic [2:0] code);
        case (code)
            3'd0: return 8;
            3'd1: return 16;
            3'd2: return 32;
            3'd3: return 48;
            3'd4: return 64;
            3'd5: return 96;
            3'd6: return 128;
            default: return 224;
        endcase
    endfunction

    function automatic logic [63:0] ref_frame(input logic rd, input logic [4:0] pa,
                                              input logic [4:0] ra, input logic [15:0] wd);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, wd};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- transaction driver ------------------------------------
    // mid_cfg: write new_code during the frame; mid_start: issue a stray start
    task automatic run_txn(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [2:0] used_code,
                           input bit mid_cfg, input logic [2:0] new_code,
                           input bit mid_start);
        logic [63:0] fr;
        int per, half, bad_o, bad_oe, first_bad;
        per = ref_period(used_code);
        half = per / 2;
        fr = ref_frame(rd, pa, ra, wd);
        phy_val = 16'($urandom());
        @(negedge clk);
        cmd_read = rd; cmd_phy = pa; cmd_reg = ra; cmd_wdata = wd; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        check(busy === 1'b1 && done === 1'b0, "R8", "busy/done at start", {busy, done}, 2);
        repeat (per * 5) @(negedge clk);
        if (mid_cfg) begin
            cfg_div_code = new_code; cfg_wr = 1'b1;
            @(negedge clk);
            cfg_wr = 1'b0;
        end
        if (mid_start) begin
            cmd_read = ~rd; cmd_phy = ~pa; cmd_reg = ~ra; cmd_wdata = ~wd; cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
        end
        while (busy === 1'b1) @(negedge clk);
        check(done === 1'b1, "R8", "done when busy drops", done, 1);
        check(busy_cnt == 128 * half, "R8", "busy length", busy_cnt, 128 * half);
        check(rise_cyc1 - rise_cyc0 == per, "R3", "mdc period", rise_cyc1 - rise_cyc0, per);
        check(fall_cyc0 - rise_cyc0 == half, "R3", "mdc high time", fall_cyc0 - rise_cyc0, half);
        check(rise_cnt == 64, "R1", "mdc rising edges", rise_cnt, 64);
        bad_o = 0; bad_oe = 0; first_bad = -1;
        for (int i = 0; i < 64; i++) begin
            if (!rd || i < 46) begin
                if (cap_o[i] !== fr[63 - i]) begin
                    bad_o++;
                    if (first_bad < 0) first_bad = i;
                end
                if (cap_oe[i] !== 1'b1) bad_oe++;
            end else if (cap_oe[i] !== 1'b0) begin
                bad_oe++;
            end
        end
        if (rd) begin
            check(bad_o == 0, "R2", "read header bits wrong (first index)", first_bad, -1);
            check(bad_oe == 0, "R2", "read oe pattern mismatches", bad_oe, 0);
            check(rd_data === phy_val, "R2", "read data", int'(rd_data), int'(phy_val));
        end else begin
            check(bad_o == 0, "R1", "write frame bits wrong (first index)", first_bad, -1);
            check(bad_oe == 0, "R1", "write oe mismatches", bad_oe, 0);
        end
        repeat (20) @(negedge clk);
        check(mdc === 1'b0 && mdio_oe === 1'b0, "R7", "idle mdc/oe", {mdc, mdio_oe}, 0);
        check(done === 1'b1 && busy === 1'b0, "R9", "no second frame after stray start",
              {busy, done}, 1);
    endtask

    // ---------------- watchdog ----------------------------------------------
    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // ---------------- main sequence -----------------------------------------
    initial begin
        logic [2:0] cur;
        void'($urandom(32'd20250611));
        repeat (4) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0 &&
              rd_data === 16'h0, "R10", "reset outputs", {busy, done, mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: no configuration write yet -> divide by 32
        run_txn(1'b0, 5'h15, 5'h0A, 16'hA5C3, 3'd2, 0, 3'd0, 0);

        // R5: code written mid-frame only affects the next frame; R9 stray start
        run_txn(1'b1, 5'h03, 5'h1F, 16'h0000, 3'd2, 1, 3'd0, 1);
        run_txn(1'b0, 5'h00, 5'h00, 16'hFFFF, 3'd0, 0, 3'd0, 0);

        // R3: every code with random fields, alternating reads and writes
        for (int c = 1; c < 8; c++) begin
            @(negedge clk);
            cfg_div_code = 3'(c); cfg_wr = 1'b1;
            @(negedge clk);
            cfg_wr = 1'b0;
            cur = 3'(c);
            run_txn(1'($urandom()), 5'($urandom()), 5'($urandom()), 16'($urandom()),
                    cur, 0, 3'd0, (c % 3) == 0);
        end

        // corner: register 31, all-ones read data path at fastest clock
        @(negedge clk);
        cfg_div_code = 3'd0; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        run_txn(1'b1, 5'h1F, 5'h1F, 16'h0000, 3'd0, 1, 3'd5, 0);
        run_txn(1'b0, 5'h1F, 5'h1F, 16'h8001, 3'd5, 0, 3'd0, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule